// File: doc/BRIEF.md
# Execute Stage: Arithmetic, Compare and Branch Resolution

This block is the execute stage of a small 32-bit load/store processor. Each cycle it may receive one decoded operation with an operation code, two register operands, an optional immediate constant, the program counter and a signed branch offset. The program counter arrives already advanced past the current instruction, so it equals the instruction address plus 4. From these inputs the block computes the destination-register result and its write enable. It also resolves whether a branch is taken, gives the next program counter, and gives the value and write enable for the link register.

The block holds three status flags, called negative, equal and greater, in a small register. Only the compare operation writes that register. Conditional branches read the flags as they were at the start of the cycle. If an operation code is invalid, or an immediate is used with an operation that cannot take one, the block raises an error. It then freezes the program counter at the address of the faulting instruction and stays halted until reset. All datapath outputs are combinational. The issuing stage provides a plain `op_valid_i` strobe and receives no back-pressure, because the block accepts one operation in every cycle.

Top module: `exec_core`

## Requirements
- R1: With `op_valid_i` high, ADD (0), SUB (1), AND (2), ORR (3), EOR (4) and BIC (5) drive `rd_we_o` high in the same cycle. `rd_wdata_o` is a+b, a−b, a&b, a|b, a^b or a&~b respectively, all modulo 2^32.
- R2: When `use_imm_i`=1, ADD (0), MOV (7) and CMP (8) use `imm_i` as the second operand and ignore `opb_i`. MOV writes its second operand unchanged.
- R3: MUL (6) writes the low 32 bits of a×b with bit 31 forced to zero.
- R4: CMP (8) writes nothing to the register file. At the next clock edge it replaces the stored flags `flags_o` = {N,Z,C} (bit 2 = N, bit 1 = Z, bit 0 = C) with exactly one set bit. N is set when a<b and Z when a=b, both using an unsigned 32-bit comparison. C is set when a>b.
- R5: No operation other than an accepted CMP changes `flags_o`. This includes idle cycles and faulting operations.
- R6: For B (9), BL (10), BEQ (11), BNE (12), BGT (13) and BLT (14), the target is `pc_i` − 4 + `offset_i`. When the branch is taken, `br_taken_o`=1 and `pc_next_o` equals the target. Otherwise `pc_next_o` = `pc_i`.
- R7: BL always branches. It drives `link_we_o`=1 with `link_data_o` = `pc_i` and does not write `rd_we_o`.
- R8: B is always taken. BEQ is taken when Z=1, BNE when Z=0, BGT when C=1 and BLT when N=1, each using the flags stored before this cycle.
- R9: A valid operation with code 15, or with `use_imm_i`=1 on any code other than 0, 7 or 8, raises `err_o` in that cycle. It causes no write, no branch and no flag change, and `pc_next_o` = `pc_i` − 4.
- R10: After a fault, `halt_o` stays high until reset. While it is high, every operation is ignored: `rd_we_o`, `link_we_o` and `br_taken_o` stay low, `err_o` stays low, and `pc_next_o` = `pc_i` − 4.
- R11: Reset clears the flags to 000 and leaves the block not halted. With `op_valid_i` low there is no write and no branch, and `pc_next_o` = `pc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | An operation is present this cycle |
| opcode_i | input | 4 | Operation code |
| use_imm_i | input | 1 | Second operand taken from `imm_i` |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 32 | Immediate constant |
| pc_i | input | 32 | Program counter, already advanced by 4 |
| offset_i | input | 32 | Signed branch offset in bytes |
| rd_we_o | output | 1 | Destination register write enable |
| rd_wdata_o | output | 32 | Destination register value |
| br_taken_o | output | 1 | Branch taken |
| pc_next_o | output | 32 | Next program counter |
| link_we_o | output | 1 | Link register write enable |
| link_data_o | output | 32 | Link register value |
| flags_o | output | 3 | Stored flags {N,Z,C} |
| err_o | output | 1 | Faulting operation this cycle |
| halt_o | output | 1 | Block halted (fault now or earlier) |

## Verification
The bench compares values near the sign boundary to check that the comparison is unsigned. A signed comparison would set N instead of C for 0x80000000 against 1. It multiplies operands whose product has bit 31 set, and a multiplier without the mask would leak that bit. It issues a conditional branch immediately after a compare and again after an arithmetic operation. A design that updated the flags combinationally, or let other operations touch them, would then take the wrong branch. It also checks that a fault freezes the program counter at the instruction address and that the halt persists across later valid operations.

// File: rtl/exec_pkg.sv
package exec_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_ORR = 4'd3,
    OP_EOR = 4'd4,
    OP_BIC = 4'd5,
    OP_MUL = 4'd6,
    OP_MOV = 4'd7,
    OP_CMP = 4'd8,
    OP_B   = 4'd9,
    OP_BL  = 4'd10,
    OP_BEQ = 4'd11,
    OP_BNE = 4'd12,
    OP_BGT = 4'd13,
    OP_BLT = 4'd14,
    OP_BAD = 4'd15
  } op_e;

  localparam int FLAG_W = 3;
  localparam int FL_N   = 2;
  localparam int FL_Z   = 1;
  localparam int FL_C   = 0;
endpackage

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] result,
  output logic              writes
);
  localparam logic [DATA_W-1:0] MUL_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] product;
  assign product = a * b;

  always_comb begin
    result = '0;
    writes = 1'b1;
    unique case (op)
      OP_ADD:  result = a + b;
      OP_SUB:  result = a - b;
      OP_AND:  result = a & b;
      OP_ORR:  result = a | b;
      OP_EOR:  result = a ^ b;
      OP_BIC:  result = a & ~b;
      OP_MUL:  result = product & MUL_MASK;
      OP_MOV:  result = b;
      default: writes = 1'b0;
    endcase
  end
endmodule

// File: rtl/exec_cmp.sv
module exec_cmp
  import exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [FLAG_W-1:0] flags
);
  always_comb begin
    flags = '0;
    if (a < b)       flags[FL_N] = 1'b1;
    else if (a == b) flags[FL_Z] = 1'b1;
    else             flags[FL_C] = 1'b1;
  end
endmodule

// File: rtl/exec_branch.sv
module exec_branch
  import exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op,
  input  logic [FLAG_W-1:0] flags,
  input  logic [DATA_W-1:0] pc_adv,
  input  logic [DATA_W-1:0] offset,
  output logic              taken,
  output logic              link,
  output logic [DATA_W-1:0] target
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(4);

  assign target = pc_adv - STEP + offset;

  always_comb begin
    taken = 1'b0;
    link  = 1'b0;
    unique case (op)
      OP_B:    taken = 1'b1;
      OP_BL:   begin taken = 1'b1; link = 1'b1; end
      OP_BEQ:  taken = flags[FL_Z];
      OP_BNE:  taken = ~flags[FL_Z];
      OP_BGT:  taken = flags[FL_C];
      OP_BLT:  taken = flags[FL_N];
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/exec_core.sv
module exec_core
  import exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  logic [3:0]        opcode_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] offset_i,
  output logic              rd_we_o,
  output logic [DATA_W-1:0] rd_wdata_o,
  output logic              br_taken_o,
  output logic [DATA_W-1:0] pc_next_o,
  output logic              link_we_o,
  output logic [DATA_W-1:0] link_data_o,
  output logic [2:0]        flags_o,
  output logic              err_o,
  output logic              halt_o
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(4);

  op_e               op;
  logic              imm_ok;
  logic              illegal;
  logic              fire;
  logic [DATA_W-1:0] b_sel;
  logic [DATA_W-1:0] alu_res;
  logic              alu_wr;
  logic [FLAG_W-1:0] cmp_flags;
  logic [FLAG_W-1:0] flags_q;
  logic              halted_q;
  logic              br_take;
  logic              br_link;
  logic [DATA_W-1:0] br_target;

  assign op      = op_e'(opcode_i);
  assign imm_ok  = (op == OP_ADD) || (op == OP_MOV) || (op == OP_CMP);
  assign illegal = (op == OP_BAD) || (use_imm_i && !imm_ok);
  assign fire    = op_valid_i && !halted_q && !illegal;
  assign b_sel   = use_imm_i ? imm_i : opb_i;

  exec_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (op),
    .a      (opa_i),
    .b      (b_sel),
    .result (alu_res),
    .writes (alu_wr)
  );

  exec_cmp #(.DATA_W(DATA_W)) u_cmp (
    .a     (opa_i),
    .b     (b_sel),
    .flags (cmp_flags)
  );

  exec_branch #(.DATA_W(DATA_W)) u_br (
    .op     (op),
    .flags  (flags_q),
    .pc_adv (pc_i),
    .offset (offset_i),
    .taken  (br_take),
    .link   (br_link),
    .target (br_target)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '0;
      halted_q <= 1'b0;
    end else begin
      if (fire && op == OP_CMP) flags_q <= cmp_flags;
      if (err_o)                halted_q <= 1'b1;
    end
  end

  assign err_o       = op_valid_i && !halted_q && illegal;
  assign halt_o      = halted_q || err_o;
  assign rd_we_o     = fire && alu_wr;
  assign rd_wdata_o  = alu_res;
  assign br_taken_o  = fire && br_take;
  assign link_we_o   = fire && br_link;
  assign link_data_o = pc_i;
  assign flags_o     = flags_q;

  always_comb begin
    if (halt_o)          pc_next_o = pc_i - STEP;
    else if (br_taken_o) pc_next_o = br_target;
    else                 pc_next_o = pc_i;
  end
endmodule

// File: rtl/exec_core_chk.sv
module exec_core_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid_i,
  input logic [3:0]        opcode_i,
  input logic              rd_we_o,
  input logic [DATA_W-1:0] rd_wdata_o,
  input logic              br_taken_o,
  input logic              link_we_o,
  input logic [2:0]        flags_o,
  input logic              err_o,
  input logic              halt_o
);
  localparam logic [3:0] C_MUL = 4'd6;
  localparam logic [3:0] C_CMP = 4'd8;

  p_mul_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we_o && opcode_i == C_MUL) |-> !rd_wdata_o[DATA_W-1]);

  p_cmp_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && !halt_o && opcode_i == C_CMP) |=> ($countones(flags_o) == 1));

  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid_i && !halt_o && opcode_i == C_CMP) |=> $stable(flags_o));

  p_link_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> (br_taken_o && !rd_we_o));

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!rd_we_o && !br_taken_o && !link_we_o));

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |=> (halt_o && !err_o && !rd_we_o && !br_taken_o));

  p_flags_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags_o) <= 1);
endmodule

bind exec_core exec_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid_i (op_valid_i),
  .opcode_i   (opcode_i),
  .rd_we_o    (rd_we_o),
  .rd_wdata_o (rd_wdata_o),
  .br_taken_o (br_taken_o),
  .link_we_o  (link_we_o),
  .flags_o    (flags_o),
  .err_o      (err_o),
  .halt_o     (halt_o)
);

// File: tb/exec_core_tb_top.sv
module exec_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [3:0]  opcode_i = '0;
  logic        use_imm_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0, imm_i = '0, pc_i = '0, offset_i = '0;
  logic        rd_we_o, br_taken_o, link_we_o, err_o, halt_o;
  logic [31:0] rd_wdata_o, pc_next_o, link_data_o;
  logic [2:0]  flags_o;

  always #5 clk = ~clk;

  exec_core dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .opcode_i(opcode_i),
    .use_imm_i(use_imm_i), .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i),
    .pc_i(pc_i), .offset_i(offset_i), .rd_we_o(rd_we_o), .rd_wdata_o(rd_wdata_o),
    .br_taken_o(br_taken_o), .pc_next_o(pc_next_o), .link_we_o(link_we_o),
    .link_data_o(link_data_o), .flags_o(flags_o), .err_o(err_o), .halt_o(halt_o)
  );

  typedef struct packed {
    logic        we;
    logic [31:0] wdata;
    logic        br;
    logic [31:0] pcn;
    logic        lwe;
    logic [31:0] ldata;
    logic        err;
    logic        halt;
    logic [2:0]  flags;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  logic [2:0] m_flags = 3'b000;
  logic       m_halt  = 1'b0;
  bit         done    = 1'b0;

  function automatic obs_t mask_obs(obs_t o);
    obs_t r = o;
    if (!r.we)  r.wdata = '0;
    if (!r.lwe) r.ldata = '0;
    return r;
  endfunction

  task automatic drive(input bit v, input logic [3:0] op, input bit ui,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] im,
                       input logic [31:0] pc, input logic [31:0] off, input string tag);
    obs_t e;
    logic [31:0] bs;
    bit ill, fire, take;
    @(negedge clk);
    op_valid_i = v; opcode_i = op; use_imm_i = ui; opa_i = a; opb_i = b;
    imm_i = im; pc_i = pc; offset_i = off;
    bs   = ui ? im : b;
    ill  = (op == 4'd15) || (ui && !(op == 4'd0 || op == 4'd7 || op == 4'd8));
    fire = v && !m_halt && !ill;
    e = '0;
    e.flags = m_flags;
    e.err   = v && !m_halt && ill;
    e.halt  = m_halt || e.err;
    case (op)
      4'd0: e.wdata = a + bs;
      4'd1: e.wdata = a - bs;
      4'd2: e.wdata = a & bs;
      4'd3: e.wdata = a | bs;
      4'd4: e.wdata = a ^ bs;
      4'd5: e.wdata = a & ~bs;
      4'd6: e.wdata = (a * bs) & 32'h7FFF_FFFF;
      4'd7: e.wdata = bs;
      default: e.wdata = '0;
    endcase
    e.we = fire && (op <= 4'd7);
    case (op)
      4'd9, 4'd10: take = 1'b1;
      4'd11: take = m_flags[1];
      4'd12: take = !m_flags[1];
      4'd13: take = m_flags[0];
      4'd14: take = m_flags[2];
      default: take = 1'b0;
    endcase
    e.br    = fire && take;
    e.lwe   = fire && (op == 4'd10);
    e.ldata = pc;
    if (e.halt)    e.pcn = pc - 32'd4;
    else if (e.br) e.pcn = pc - 32'd4 + off;
    else           e.pcn = pc;
    exp_q.push_back(mask_obs(e));
    tag_q.push_back(tag);
    if (fire && op == 4'd8)
      m_flags = (a < bs) ? 3'b100 : (a == bs) ? 3'b010 : 3'b001;
    if (e.err) m_halt = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    op_valid_i = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_flags = 3'b000;
    m_halt = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        obs_t act, e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = mask_obs('{rd_we_o, rd_wdata_o, br_taken_o, pc_next_o, link_we_o,
                         link_data_o, err_o, halt_o, flags_o});
        n_checks++;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, act, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    do_reset();
    drive(0, 4'd0, 0, 32'd1, 32'd2, 0, 32'h100, 0, "R11 reset idle");
    drive(1, 4'd0, 0, 32'd5, 32'd7, 0, 32'h104, 0, "R1 add");
    drive(1, 4'd0, 0, 32'hFFFF_FFFF, 32'd2, 0, 32'h108, 0, "R1 add wrap");
    drive(1, 4'd1, 0, 32'd3, 32'd5, 0, 32'h10C, 0, "R1 sub");
    drive(1, 4'd2, 0, 32'hF0F0_1234, 32'hFF00_FFFF, 0, 32'h110, 0, "R1 and");
    drive(1, 4'd3, 0, 32'hF000_0001, 32'h0F00_0010, 0, 32'h114, 0, "R1 orr");
    drive(1, 4'd4, 0, 32'hAAAA_5555, 32'hFFFF_0000, 0, 32'h118, 0, "R1 eor");
    drive(1, 4'd5, 0, 32'h0000_F0F0, 32'h0000_FF00, 0, 32'h11C, 0, "R1 bic");
    drive(1, 4'd0, 1, 32'd10, 32'd999, 32'h20, 32'h120, 0, "R2 add imm");
    drive(1, 4'd7, 1, 32'd0, 32'd999, 32'hABCD, 32'h124, 0, "R2 mov imm");
    drive(1, 4'd7, 0, 32'd0, 32'h1357_9BDF, 32'd5, 32'h128, 0, "R2 mov reg");
    drive(1, 4'd6, 0, 32'h4000_0000, 32'd2, 0, 32'h12C, 0, "R3 mul msb");
    drive(1, 4'd6, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 32'h130, 0, "R3 mul neg");
    drive(1, 4'd6, 0, 32'h0001_2345, 32'd3, 0, 32'h134, 0, "R3 mul");
    drive(1, 4'd8, 0, 32'd5, 32'd9, 0, 32'h138, 0, "R4 cmp lt");
    drive(1, 4'd14, 0, 0, 0, 0, 32'h13C, 32'h20, "R8 blt taken");
    drive(1, 4'd13, 0, 0, 0, 0, 32'h140, 32'h20, "R8 bgt not");
    drive(1, 4'd11, 0, 0, 0, 0, 32'h144, 32'h20, "R8 beq not");
    drive(1, 4'd8, 1, 32'h8000_0000, 32'd7, 32'd1, 32'h148, 0, "R4 cmp unsigned gt");
    drive(1, 4'd13, 0, 0, 0, 0, 32'h14C, 32'hFFFF_FFF0, "R8 bgt taken back");
    drive(1, 4'd8, 0, 32'd42, 32'd42, 0, 32'h150, 0, "R4 cmp eq");
    drive(1, 4'd0, 0, 32'd1, 32'd1, 0, 32'h154, 0, "R5 add keeps flags");
    drive(0, 4'd8, 0, 32'd1, 32'd2, 0, 32'h158, 0, "R5 idle cmp ignored");
    drive(1, 4'd11, 0, 0, 0, 0, 32'h15C, 32'h8, "R8 beq taken");
    drive(1, 4'd12, 0, 0, 0, 0, 32'h160, 32'h8, "R8 bne not");
    drive(1, 4'd9, 0, 0, 0, 0, 32'h104, 32'hFFFF_FFF8, "R6 b backward");
    drive(1, 4'd10, 0, 0, 0, 0, 32'h200, 32'h40, "R7 bl link");
    drive(1, 4'd2, 1, 32'd1, 32'd1, 32'd1, 32'h300, 0, "R9 imm on and");
    drive(1, 4'd0, 0, 32'd1, 32'd1, 0, 32'h304, 0, "R10 halted add");
    drive(1, 4'd8, 0, 32'd1, 32'd9, 0, 32'h308, 0, "R10 halted cmp");
    drive(1, 4'd9, 0, 0, 0, 0, 32'h30C, 32'h40, "R10 halted b");
    drive(1, 4'd0, 0, 32'd1, 32'd1, 0, 32'h310, 0, "R5 flags kept halted");
    do_reset();
    drive(0, 4'd0, 0, 0, 0, 0, 32'h400, 0, "R11 reset clears");
    drive(1, 4'd15, 0, 0, 0, 0, 32'h404, 0, "R9 bad opcode");
    drive(1, 4'd15, 0, 0, 0, 0, 32'h408, 0, "R10 no second err");
    drive(0, 4'd0, 0, 0, 0, 0, 32'h40C, 0, "R10 idle halted");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule